// File: doc/BRIEF.md
# Multi-Ring Interconnect Data Arbiter

This block is the central data arbiter for a ring interconnect that joins a set of element ports through several unidirectional data rings, half of them turning clockwise and half counter-clockwise. A port asks to send a transfer by raising a request with a destination port and a length in 16-byte beats. The arbiter picks a ring and so a direction for the transfer. It reserves the hop segments the transfer crosses for the length of the transfer. Several transfers may share one ring at the same time, as long as their segments are disjoint, up to a fixed limit per ring.

Each cycle, a first round-robin stage picks one port from those whose request can be served now. A second round-robin stage then picks a ring from those that can carry that port's path. The grant is a one-cycle pulse on the winning port, with the ring index beside it. A per-ring map of reserved segments is brought out so that the ring datapath can steer data. The ring datapath itself is outside this block.

Top module: `ring_data_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no grant is raised and every bit of the segment map is zero.
- R2: At most one port is granted per cycle. Among the ports that can be served, the first one at or after the port pointer wins, and the pointer then moves to the winner plus one, wrapping at the last port.
- R3: Among the rings that can carry the winner's path, the first one at or after the ring pointer is chosen, and the ring pointer then moves to that ring plus one, wrapping.
- R4: Rings 0 to N_RINGS/2-1 run clockwise and the rest run counter-clockwise. The clockwise hop count from s to d is (d-s) mod N_PORTS and the counter-clockwise count is (s-d) mod N_PORTS. Only the direction with the smaller count is used, and both directions are allowed when the counts are equal, so a path never exceeds N_PORTS/2 hops.
- R5: Segment map bit r*N_PORTS+k is set while an active transfer on ring r crosses segment k. On a clockwise ring, segment k links port k to port k+1. On a counter-clockwise ring, it links port k to port k-1 (mod N_PORTS).
- R6: A transfer is placed only on a ring where none of its segments is already reserved. A request whose path collides on every allowed ring waits, while disjoint transfers share a ring.
- R7: A ring never carries more than MAX_PER_RING transfers. A request with a free path is still held off when every allowed ring is at that limit.
- R8: A transfer of L beats keeps its segments reserved for exactly L cycles after the grant edge, then releases them.
- R9: A request whose destination port is already the target of an active transfer is not granted.
- R10: A port with its own transfer still active is not granted again. A request whose destination equals the source, whose destination is N_PORTS or above, or whose length is zero is never granted.
- R11: grant is a single-cycle pulse, and grant_ring carries the chosen ring for the granted port in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_PORTS | Per-port request, held until granted |
| req_dest | input | N_PORTS*IDW | Destination port per source, IDW = clog2(N_PORTS) |
| req_len | input | N_PORTS*LEN_W | Transfer length in beats per source |
| grant | output | N_PORTS | One-cycle grant pulse per port |
| grant_ring | output | N_PORTS*RW | Ring index for each granted port, RW = clog2(N_RINGS) |
| seg_busy | output | N_RINGS*N_PORTS | Reserved segment map, ring-major |

## Verification
The bench builds the block with 12 ports, 4 rings (two per direction) and at most 3 transfers per ring, so a distance of 6 reaches the equal-direction case in both orientations. The length field is widened to 6 bits. Holds of 60 beats can then keep six one-hop transfers active on the two counter-clockwise rings while blocked requests are probed for segment collisions, the ring limit, a busy destination and a busy source. Table vectors walk the ring pointer through both directions and a wrap of the segment index past port 11.

// File: rtl/rda_pkg.sv
package rda_pkg;
   // Width of an index that can name any of n items (at least one bit).
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rda_rr_pick.sv
module rda_rr_pick #(
   parameter int W = 4,
   localparam int PW = rda_pkg::idx_w(W)
) (
   input  logic [W-1:0]  req,
   input  logic [PW-1:0] ptr,
   output logic          any,
   output logic [PW-1:0] idx
);
   int j;
   always_comb begin
      any = 1'b0;
      idx = '0;
      j   = 0;
      for (int i = 0; i < W; i++) begin
         j = (int'(ptr) + i) % W;
         if (!any && req[j]) begin
            any = 1'b1;
            idx = PW'(j);
         end
      end
   end
endmodule

// File: rtl/rda_path.sv
module rda_path #(
   parameter int N   = 12,
   parameter int SRC = 0,
   localparam int IDW = rda_pkg::idx_w(N)
) (
   input  logic [IDW-1:0] dest,
   output logic           legal,
   output logic           cw_ok,
   output logic           ccw_ok,
   output logic [N-1:0]   cw_mask,
   output logic [N-1:0]   ccw_mask
);
   int d, fwd, bwd;
   always_comb begin
      d        = int'(dest);
      legal    = (d < N) && (d != SRC);
      fwd      = (d + N - SRC) % N;
      bwd      = (SRC + N - d) % N;
      cw_ok    = legal && (fwd <= bwd);
      ccw_ok   = legal && (bwd <= fwd);
      cw_mask  = '0;
      ccw_mask = '0;
      for (int k = 0; k < N; k++) begin
         if (legal && k < fwd) cw_mask[(SRC + k) % N] = 1'b1;
         if (legal && k < bwd) ccw_mask[(SRC + N - k) % N] = 1'b1;
      end
   end
endmodule

// File: rtl/rda_track.sv
module rda_track #(
   parameter int N     = 12,
   parameter int R     = 4,
   parameter int LW    = 4,
   parameter int MAXX  = 3,
   localparam int IDW  = rda_pkg::idx_w(N),
   localparam int RW   = rda_pkg::idx_w(R),
   localparam int CNTW = $clog2(N + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [IDW-1:0]           load_port,
   input  logic [RW-1:0]            load_ring,
   input  logic [N-1:0]             load_mask,
   input  logic [IDW-1:0]           load_dest,
   input  logic [LW-1:0]            load_len,
   output logic [R-1:0][N-1:0]      seg_map,
   output logic [R-1:0][CNTW-1:0]   ring_cnt,
   output logic [N-1:0]             rx_busy,
   output logic [N-1:0]             tx_busy
);
   logic [N-1:0]          act;
   logic [N-1:0][RW-1:0]  ring_q;
   logic [N-1:0][N-1:0]   mask_q;
   logic [N-1:0][IDW-1:0] dest_q;
   logic [N-1:0][LW-1:0]  cnt_q;
   logic [R-1:0]          clash;
   logic                  rx_dup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= '0;
         ring_q <= '0;
         mask_q <= '0;
         dest_q <= '0;
         cnt_q  <= '0;
      end else begin
         for (int p = 0; p < N; p++) begin
            if (load && int'(load_port) == p) begin
               act[p]    <= 1'b1;
               ring_q[p] <= load_ring;
               mask_q[p] <= load_mask;
               dest_q[p] <= load_dest;
               cnt_q[p]  <= load_len;
            end else if (act[p]) begin
               cnt_q[p] <= cnt_q[p] - LW'(1);
               if (cnt_q[p] == LW'(1)) act[p] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      seg_map  = '0;
      ring_cnt = '0;
      rx_busy  = '0;
      clash    = '0;
      rx_dup   = 1'b0;
      for (int p = 0; p < N; p++) begin
         if (act[p]) begin
            for (int r = 0; r < R; r++) begin
               if (int'(ring_q[p]) == r) begin
                  clash[r]    = clash[r] | (|(seg_map[r] & mask_q[p]));
                  seg_map[r]  = seg_map[r] | mask_q[p];
                  ring_cnt[r] = ring_cnt[r] + CNTW'(1);
               end
            end
            for (int q = 0; q < N; q++) begin
               if (int'(dest_q[p]) == q) begin
                  rx_dup     = rx_dup | rx_busy[q];
                  rx_busy[q] = 1'b1;
               end
            end
         end
      end
   end

   assign tx_busy = act;

   // R6: transfers sharing a ring never hold a common segment
   p_no_seg_clash_r6: assert property (@(posedge clk) disable iff (!rst_n) clash == '0);
   // R9: a destination receives from one transfer at a time
   p_rx_single_r9: assert property (@(posedge clk) disable iff (!rst_n) !rx_dup);

   for (genvar r = 0; r < R; r++) begin : g_cap
      // R7: per-ring occupancy limit
      p_ring_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ring_cnt[r] <= CNTW'(MAXX));
   end

   for (genvar p = 0; p < N; p++) begin : g_hold
      // R8: segments stay reserved until the last beat, then free
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (act[p] && cnt_q[p] != LW'(1)) |=> act[p]);
      p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (act[p] && cnt_q[p] == LW'(1)) |=> !act[p]);
   end
endmodule

// File: rtl/ring_data_arb.sv
module ring_data_arb #(
   parameter int N_PORTS      = 12,
   parameter int N_RINGS      = 4,
   parameter int MAX_PER_RING = 3,
   parameter int LEN_W        = 4,
   localparam int IDW  = rda_pkg::idx_w(N_PORTS),
   localparam int RW   = rda_pkg::idx_w(N_RINGS),
   localparam int HALF = N_RINGS / 2,
   localparam int CNTW = $clog2(N_PORTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_PORTS-1:0]         req_valid,
   input  logic [N_PORTS*IDW-1:0]     req_dest,
   input  logic [N_PORTS*LEN_W-1:0]   req_len,
   output logic [N_PORTS-1:0]         grant,
   output logic [N_PORTS*RW-1:0]      grant_ring,
   output logic [N_RINGS*N_PORTS-1:0] seg_busy
);
   if (N_RINGS < 2 || (N_RINGS % 2) != 0) begin : g_bad_rings
      $error("N_RINGS must be even and at least 2");
   end
   if (N_PORTS < 3) begin : g_bad_ports
      $error("N_PORTS must be at least 3");
   end
   if (MAX_PER_RING < 1 || LEN_W < 1) begin : g_bad_misc
      $error("MAX_PER_RING and LEN_W must be positive");
   end

   logic [N_PORTS-1:0]                legal, cw_ok, ccw_ok, port_ok;
   logic [N_PORTS-1:0][N_PORTS-1:0]   cw_m, ccw_m;
   logic [N_PORTS-1:0][N_RINGS-1:0]   elig;
   logic [N_RINGS-1:0][N_PORTS-1:0]   seg_map;
   logic [N_RINGS-1:0][CNTW-1:0]      ring_cnt;
   logic [N_PORTS-1:0]                rx_busy, tx_busy;

   // Stage 1 / stage 2 results
   logic                win_any, ring_any;
   logic [IDW-1:0]      win_port;
   logic [RW-1:0]       win_ring;
   logic [N_RINGS-1:0]  win_elig;
   logic [N_PORTS-1:0]  win_cw, win_ccw, win_mask;
   logic [IDW-1:0]      win_dest;
   logic [LEN_W-1:0]    win_len;

   logic [IDW-1:0]               port_ptr;
   logic [RW-1:0]                ring_ptr;
   logic [N_PORTS-1:0]           grant_q;
   logic [N_PORTS-1:0][RW-1:0]   gring_q;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_path
      rda_path #(.N(N_PORTS), .SRC(p)) u_path (
         .dest     (req_dest[p*IDW +: IDW]),
         .legal    (legal[p]),
         .cw_ok    (cw_ok[p]),
         .ccw_ok   (ccw_ok[p]),
         .cw_mask  (cw_m[p]),
         .ccw_mask (ccw_m[p])
      );
   end

   // Ring eligibility per requester and stage-one candidate set
   logic                dir_ok, rx_hit;
   logic [N_PORTS-1:0]  path_m;
   always_comb begin
      elig    = '0;
      port_ok = '0;
      dir_ok  = 1'b0;
      rx_hit  = 1'b0;
      path_m  = '0;
      for (int p = 0; p < N_PORTS; p++) begin
         for (int r = 0; r < N_RINGS; r++) begin
            dir_ok     = (r < HALF) ? cw_ok[p] : ccw_ok[p];
            path_m     = (r < HALF) ? cw_m[p]  : ccw_m[p];
            elig[p][r] = dir_ok && ((path_m & seg_map[r]) == '0)
                         && (ring_cnt[r] < CNTW'(MAX_PER_RING));
         end
         rx_hit = 1'b0;
         for (int q = 0; q < N_PORTS; q++) begin
            if (int'(req_dest[p*IDW +: IDW]) == q) rx_hit = rx_hit | rx_busy[q];
         end
         port_ok[p] = req_valid[p] && legal[p]
                      && (req_len[p*LEN_W +: LEN_W] != '0)
                      && !tx_busy[p] && !rx_hit && (|elig[p]);
      end
   end

   rda_rr_pick #(.W(N_PORTS)) u_port_pick (
      .req (port_ok),
      .ptr (port_ptr),
      .any (win_any),
      .idx (win_port)
   );

   always_comb begin
      win_elig = '0;
      win_cw   = '0;
      win_ccw  = '0;
      win_dest = '0;
      win_len  = '0;
      for (int p = 0; p < N_PORTS; p++) begin
         if (int'(win_port) == p) begin
            win_elig = elig[p];
            win_cw   = cw_m[p];
            win_ccw  = ccw_m[p];
            win_dest = req_dest[p*IDW +: IDW];
            win_len  = req_len[p*LEN_W +: LEN_W];
         end
      end
   end

   rda_rr_pick #(.W(N_RINGS)) u_ring_pick (
      .req (win_elig),
      .ptr (ring_ptr),
      .any (ring_any),
      .idx (win_ring)
   );

   assign win_mask = (int'(win_ring) < HALF) ? win_cw : win_ccw;

   rda_track #(.N(N_PORTS), .R(N_RINGS), .LW(LEN_W), .MAXX(MAX_PER_RING)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (win_any && ring_any),
      .load_port (win_port),
      .load_ring (win_ring),
      .load_mask (win_mask),
      .load_dest (win_dest),
      .load_len  (win_len),
      .seg_map   (seg_map),
      .ring_cnt  (ring_cnt),
      .rx_busy   (rx_busy),
      .tx_busy   (tx_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_ptr <= '0;
         ring_ptr <= '0;
         grant_q  <= '0;
         gring_q  <= '0;
      end else begin
         grant_q <= '0;
         gring_q <= '0;
         if (win_any && ring_any) begin
            for (int p = 0; p < N_PORTS; p++) begin
               if (int'(win_port) == p) begin
                  grant_q[p] <= 1'b1;
                  gring_q[p] <= win_ring;
               end
            end
            port_ptr <= (int'(win_port) == N_PORTS - 1) ? '0 : win_port + IDW'(1);
            ring_ptr <= (int'(win_ring) == N_RINGS - 1) ? '0 : win_ring + RW'(1);
         end
      end
   end

   assign grant      = grant_q;
   assign grant_ring = gring_q;
   assign seg_busy   = seg_map;

   // R2: never more than one grant per cycle
   p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
   // R4: a granted path never exceeds half the ring
   p_short_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_any && ring_any) |-> ($countones(win_mask) <= N_PORTS / 2));
   // R5: the chosen path appears in the segment map of the chosen ring
   p_seg_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_any && ring_any) |=>
         ((seg_map[$past(win_ring)] & $past(win_mask)) == $past(win_mask)));
   // R11: a port is never granted in two consecutive cycles
   p_grant_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |=> ((grant & $past(grant)) == '0));
endmodule

// File: tb/ring_data_arb_tb.sv
module ring_data_arb_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP  = 12;
   localparam int NR  = 4;
   localparam int LW  = 6;
   localparam int IDW = 4;
   localparam int RW  = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NP-1:0]       req_valid = '0;
   logic [NP*IDW-1:0]   req_dest = '0;
   logic [NP*LW-1:0]    req_len = '0;
   logic [NP-1:0]       grant;
   logic [NP*RW-1:0]    grant_ring;
   logic [NR*NP-1:0]    seg_busy;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_data_arb #(.N_PORTS(NP), .N_RINGS(NR), .MAX_PER_RING(3), .LEN_W(LW)) u_dut (
      .clk, .rst_n, .req_valid, .req_dest, .req_len, .grant, .grant_ring, .seg_busy
   );

   // {src, dest, len, expected ring, expected segment mask}, walked from reset
   localparam logic [27:0] VEC [8] = '{
      {4'd0,  4'd3,  6'd2, 2'd0, 12'h007},
      {4'd5,  4'd2,  6'd1, 2'd2, 12'h038},
      {4'd10, 4'd1,  6'd3, 2'd0, 12'hC01},
      {4'd4,  4'd10, 6'd1, 2'd1, 12'h3F0},
      {4'd4,  4'd10, 6'd1, 2'd2, 12'h81F},
      {4'd7,  4'd6,  6'd1, 2'd3, 12'h080},
      {4'd11, 4'd0,  6'd2, 2'd0, 12'h800},
      {4'd2,  4'd8,  6'd4, 2'd1, 12'h0FC}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_req(input int p, input int d, input int l);
      req_valid[p]            = 1'b1;
      req_dest[p*IDW +: IDW]  = IDW'(d);
      req_len[p*LW +: LW]     = LW'(l);
   endtask

   task automatic clr_req(input int p);
      req_valid[p] = 1'b0;
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      req_valid = '0;
      repeat (3) @(negedge clk);
      chk("R1 grant in reset", 64'(grant), 64'd0);
      chk("R1 segments in reset", 64'(seg_busy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Request alone, expect grant on the next sample with the given ring.
   task automatic one_grant(input string tag, input int p, input int d, input int l, input int ring);
      set_req(p, d, l);
      @(negedge clk);
      chk(tag, 64'(grant), 64'(1) << p);
      chk(tag, 64'(grant_ring[p*RW +: RW]), 64'(ring));
      clr_req(p);
   endtask

   task automatic blocked(input string tag, input int p, input int d, input int l, input int cyc);
      set_req(p, d, l);
      for (int c = 0; c < cyc; c++) begin
         @(negedge clk);
         chk(tag, 64'(grant), 64'd0);
      end
      clr_req(p);
   endtask

   initial begin
      do_reset();
      chk("R1 after reset grant", 64'(grant), 64'd0);
      chk("R1 after reset segments", 64'(seg_busy), 64'd0);

      // Table walk: R3 R4 R5 R8 R11
      for (int i = 0; i < 8; i++) begin
         int s, d, l, rg;
         logic [11:0] m;
         s  = int'(VEC[i][27:24]);
         d  = int'(VEC[i][23:20]);
         l  = int'(VEC[i][19:14]);
         rg = int'(VEC[i][13:12]);
         m  = VEC[i][11:0];
         set_req(s, d, l);
         @(negedge clk);
         chk("R2 table grant", 64'(grant), 64'(1) << s);
         chk("R3 R4 table ring", 64'(grant_ring[s*RW +: RW]), 64'(rg));
         chk("R5 table segments", 64'(seg_busy), 64'(m) << (rg*NP));
         clr_req(s);
         for (int c = 1; c <= l; c++) begin
            @(negedge clk);
            if (c == 1) chk("R11 grant pulse", 64'(grant), 64'd0);
            chk("R8 hold length", 64'(seg_busy), (c < l) ? (64'(m) << (rg*NP)) : 64'd0);
         end
         @(negedge clk);
      end

      // R2: two simultaneous requests, round-robin order from pointer 0
      do_reset();
      set_req(5, 6, 4);
      set_req(1, 2, 4);
      @(negedge clk);
      chk("R2 first winner", 64'(grant), 64'(1) << 1);
      chk("R3 first ring", 64'(grant_ring[1*RW +: RW]), 64'd0);
      clr_req(1);
      @(negedge clk);
      chk("R2 second winner", 64'(grant), 64'(1) << 5);
      chk("R3 second ring", 64'(grant_ring[5*RW +: RW]), 64'd1);
      clr_req(5);
      repeat (6) @(negedge clk);

      // R6: collision on both clockwise rings, disjoint path shares a ring
      do_reset();
      one_grant("R6 setup a", 0, 3, 40, 0);
      one_grant("R6 setup b", 1, 4, 40, 1);
      blocked("R6 colliding path waits", 2, 5, 4, 3);
      one_grant("R6 disjoint shares ring", 6, 9, 4, 0);
      chk("R6 shared ring map", 64'(seg_busy[0 +: NP]), 64'h1C7);
      repeat (45) @(negedge clk);

      // R7 / R9 / R10: six one-hop counter-clockwise transfers
      do_reset();
      one_grant("R7 fill", 1, 0, 60, 2);
      one_grant("R7 fill", 3, 2, 60, 3);
      one_grant("R7 fill", 5, 4, 60, 2);
      one_grant("R7 fill", 7, 6, 60, 3);
      one_grant("R7 fill", 9, 8, 60, 2);
      one_grant("R7 fill", 11, 10, 60, 3);
      chk("R7 ring2 map", 64'(seg_busy[2*NP +: NP]), 64'h222);
      chk("R7 ring3 map", 64'(seg_busy[3*NP +: NP]), 64'h888);
      blocked("R7 ring limit", 2, 1, 4, 3);
      blocked("R9 destination busy", 4, 6, 4, 3);
      blocked("R10 source busy", 1, 3, 4, 2);
      blocked("R10 self destination", 4, 4, 4, 2);
      blocked("R10 destination out of range", 4, 12, 4, 2);
      blocked("R10 zero length", 4, 5, 0, 2);
      one_grant("R10 control grant", 4, 5, 1, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule